// File: doc/BRIEF.md
# SDRAM Byte-Mask Data Path

This block sits between a memory controller and the 16-bit bidirectional data bus of a synchronous DRAM. On the write side it turns a host write beat (data plus per-byte enables) into bus drive: the output enable, the data word and the two byte-mask pins, all in the same clock. On the read side it tracks every read command through a short history register. It drives the byte masks ahead of the returning data to cover the two-clock mask latency on reads. It samples the bus at the programmed CAS latency (2 or 3 clocks) and returns the captured word with a valid flag and one valid bit per byte.

The mask pins have asymmetric timing. A mask on a write beat blocks that byte in the same clock. A mask meant for a read beat must appear two clocks before the data is sampled. The block computes both timings from the same command history. It also keeps the controller off the bus while the memory is driving it: a write beat is dropped when a read command is present, when read data is on the bus, or when read data is due on the next clock.

Both data streams are valid-only. A write beat is accepted only when not dropped, and the controller must not issue one into a read window. The read stream has no ready: the memory cannot be stalled, so the receiver must take every word in the clock it is flagged. `cas_lat` may change only while no read is in flight.

Top module: `sdram_dqpath`

## Requirements
- R1: On an accepted write beat, `dq_oe` is 1 and `dq_out` equals `wr_data` in the same clock.
- R2: On an accepted write beat, `dqm_lo` = NOT `wr_be[0]` (bits 7:0) and `dqm_hi` = NOT `wr_be[1]` (bits 15:8), in the same clock.
- R3: With `cas_lat` = 0 (latency 2), a read command sampled at edge N has `dq_in` sampled at edge N+2, and `rd_valid` is 1 in the clock after that edge.
- R4: With `cas_lat` = 1 (latency 3), the read is sampled at edge N+3, and `rd_valid` is 1 in the clock after that edge.
- R5: For a read sampled at edge C, the mask pins carry NOT `rd_be` (bit 0 lower byte, bit 1 upper byte) at edge C-2, when no write is accepted.
- R6: `rd_byte_valid[b]` equals the read's `rd_be[b]`. A byte whose enable was 0 returns 0 in `rd_data`, and an enabled byte returns the sampled `dq_in` byte.
- R7: A write beat is dropped (`dq_oe` 0, `dq_out` 0, both masks 1 unless a read mask applies) when `rd_beat` is 1, or read data is sampled at the coming edge or the one after it.
- R8: With no write beat and no read mask due, `dq_oe` is 0, `dq_out` is 0 and both mask pins are 1.
- R9: During and straight after reset, `rd_valid` and `rd_byte_valid` are 0 until a read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 1 | Read latency select: 0 = 2 clocks, 1 = 3 clocks |
| rd_beat | input | 1 | Read command issued at this edge |
| rd_be | input | 2 | Byte enables wanted for that read |
| wr_beat | input | 1 | Write beat valid |
| wr_data | input | 16 | Write data word |
| wr_be | input | 2 | Write byte enables |
| dq_in | input | 16 | Data sampled from the DRAM bus |
| dq_oe | output | 1 | Drive enable for the bus |
| dq_out | output | 16 | Data driven onto the bus |
| dqm_lo | output | 1 | Mask pin for bits 7:0 |
| dqm_hi | output | 1 | Mask pin for bits 15:8 |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | 16 | Captured read word |
| rd_byte_valid | output | 2 | Per-byte valid of the captured word |

## Verification
Random mixes of read commands, write beats and byte enables are run at both latencies, with the latency changed only after the pipeline drains. Isolated reads separate latency 2 from latency 3 by the capture edge. Back-to-back reads show that mask and data stay paired per command. Writes placed next to reads show whether the drop window is one clock too short or too long. Single-byte enables on both paths tell the lower mask from the upper and show the zero-latency write mask apart from the two-clock read mask.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  // latency select encoding on the cas_lat pin
  typedef enum logic {
    LAT2 = 1'b0,
    LAT3 = 1'b1
  } lat_sel_e;

  // mask pin level when nothing is being masked in or out
  localparam logic MASK_IDLE = 1'b1;

  function automatic int unsigned lat_clocks(input lat_sel_e sel);
    return (sel == LAT3) ? 3 : 2;
  endfunction
endpackage

// File: rtl/sdq_rd_track.sv
module sdq_rd_track #(
  parameter int unsigned NB     = 2,
  parameter int unsigned MAX_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cas_lat,
  input  logic          rd_beat,
  input  logic [NB-1:0] rd_be,
  output logic          cap_act,
  output logic [NB-1:0] cap_be,
  output logic          bus_next,
  output logic          rmask_act,
  output logic [NB-1:0] rmask_be
);
  import sdq_pkg::*;
  localparam int unsigned HW = MAX_LAT + 1;
  localparam int unsigned IW = $clog2(HW);

  // cmd_hist[k] = a read was issued k edges ago (k = 0 is this edge)
  logic [MAX_LAT-1:0]         cmd_sr;
  logic [MAX_LAT-1:0][NB-1:0] be_sr;
  logic [HW-1:0]              cmd_hist;
  logic [HW-1:0][NB-1:0]      be_hist;
  logic [IW-1:0]              lat_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_sr <= '0;
      be_sr  <= '0;
    end else begin
      cmd_sr[0] <= rd_beat;
      be_sr[0]  <= rd_be;
      for (int k = 1; k < MAX_LAT; k++) begin
        cmd_sr[k] <= cmd_sr[k-1];
        be_sr[k]  <= be_sr[k-1];
      end
    end
  end

  assign cmd_hist = {cmd_sr, rd_beat};
  assign be_hist  = {be_sr, rd_be};
  assign lat_idx  = IW'(lat_clocks(lat_sel_e'(cas_lat)));

  assign cap_act   = cmd_hist[lat_idx];
  assign cap_be    = be_hist[lat_idx];
  assign bus_next  = cmd_hist[lat_idx - IW'(1)];
  assign rmask_act = cmd_hist[lat_idx - IW'(2)];
  assign rmask_be  = be_hist[lat_idx - IW'(2)];
endmodule

// File: rtl/sdq_wr_drive.sv
module sdq_wr_drive #(
  parameter int unsigned NB     = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                 wr_beat,
  input  logic [NB*BYTE_W-1:0] wr_data,
  input  logic [NB-1:0]        wr_be,
  input  logic                 rd_beat,
  input  logic                 cap_act,
  input  logic                 bus_next,
  input  logic                 rmask_act,
  input  logic [NB-1:0]        rmask_be,
  output logic                 dq_oe,
  output logic [NB*BYTE_W-1:0] dq_out,
  output logic [NB-1:0]        dqm
);
  import sdq_pkg::*;
  logic wr_ok;

  // the memory owns the bus this clock or the next: stay off it
  assign wr_ok  = wr_beat & ~rd_beat & ~cap_act & ~bus_next;
  assign dq_oe  = wr_ok;
  assign dq_out = wr_ok ? wr_data : '0;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    always_comb begin
      if (wr_ok)          dqm[b] = ~wr_be[b];
      else if (rmask_act) dqm[b] = ~rmask_be[b];
      else                dqm[b] = MASK_IDLE;
    end
  end
endmodule

// File: rtl/sdq_rd_capture.sv
module sdq_rd_capture #(
  parameter int unsigned NB     = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_act,
  input  logic [NB-1:0]        cap_be,
  input  logic [NB*BYTE_W-1:0] dq_in,
  output logic                 rd_valid,
  output logic [NB*BYTE_W-1:0] rd_data,
  output logic [NB-1:0]        rd_byte_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap_act;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic take;
    assign take = cap_act & cap_be[b];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_byte_valid[b]             <= 1'b0;
        rd_data[b*BYTE_W +: BYTE_W]  <= '0;
      end else begin
        rd_byte_valid[b]             <= take;
        rd_data[b*BYTE_W +: BYTE_W]  <= take ? dq_in[b*BYTE_W +: BYTE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/sdram_dqpath.sv
module sdram_dqpath #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NB      = 2,
  parameter int unsigned MAX_LAT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cas_lat,
  input  logic                 rd_beat,
  input  logic [NB-1:0]        rd_be,
  input  logic                 wr_beat,
  input  logic [NB*BYTE_W-1:0] wr_data,
  input  logic [NB-1:0]        wr_be,
  input  logic [NB*BYTE_W-1:0] dq_in,
  output logic                 dq_oe,
  output logic [NB*BYTE_W-1:0] dq_out,
  output logic                 dqm_lo,
  output logic                 dqm_hi,
  output logic                 rd_valid,
  output logic [NB*BYTE_W-1:0] rd_data,
  output logic [NB-1:0]        rd_byte_valid
);
  logic          cap_act, bus_next, rmask_act;
  logic [NB-1:0] cap_be, rmask_be, dqm;

  sdq_rd_track #(.NB(NB), .MAX_LAT(MAX_LAT)) u_track (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
    .rd_beat(rd_beat), .rd_be(rd_be),
    .cap_act(cap_act), .cap_be(cap_be), .bus_next(bus_next),
    .rmask_act(rmask_act), .rmask_be(rmask_be)
  );

  sdq_wr_drive #(.NB(NB), .BYTE_W(BYTE_W)) u_wr (
    .wr_beat(wr_beat), .wr_data(wr_data), .wr_be(wr_be),
    .rd_beat(rd_beat), .cap_act(cap_act), .bus_next(bus_next),
    .rmask_act(rmask_act), .rmask_be(rmask_be),
    .dq_oe(dq_oe), .dq_out(dq_out), .dqm(dqm)
  );

  sdq_rd_capture #(.NB(NB), .BYTE_W(BYTE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_act(cap_act), .cap_be(cap_be),
    .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_byte_valid(rd_byte_valid)
  );

  assign dqm_lo = dqm[0];
  assign dqm_hi = dqm[NB-1];
endmodule

// File: rtl/sdram_dqpath_chk.sv
module sdram_dqpath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cas_lat,
  input logic        rd_beat,
  input logic        wr_beat,
  input logic [15:0] wr_data,
  input logic [1:0]  wr_be,
  input logic        dq_oe,
  input logic [15:0] dq_out,
  input logic        dqm_lo,
  input logic        dqm_hi,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic [1:0]  rd_byte_valid
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R1
  oe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (wr_beat && dq_out == wr_data));
  // R2
  write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqm_lo == ~wr_be[0] && dqm_hi == ~wr_be[1]));
  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |-> !dq_oe);
  // R6
  masked_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_byte_valid[0] |-> rd_data[7:0] == 8'h00) and
    (!rd_byte_valid[1] |-> rd_data[15:8] == 8'h00));
  // R9
  byte_valid_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_byte_valid != 2'b00) |-> rd_valid);
  // R3
  lat2_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && !cas_lat && !$past(cas_lat) && !$past(cas_lat, 2)
     && $past(rd_beat, 3)) |-> rd_valid);
  // R4
  lat3_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && cas_lat && $past(cas_lat) && $past(cas_lat, 2)
     && $past(cas_lat, 3) && $past(rd_beat, 4)) |-> rd_valid);
endmodule

bind sdram_dqpath sdram_dqpath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_beat(rd_beat),
  .wr_beat(wr_beat), .wr_data(wr_data), .wr_be(wr_be), .dq_oe(dq_oe),
  .dq_out(dq_out), .dqm_lo(dqm_lo), .dqm_hi(dqm_hi), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_byte_valid(rd_byte_valid)
);

// File: tb/test_sdram_dqpath.sv
`timescale 1ns/1ps
module test_sdram_dqpath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cas_lat = 1'b0;
  logic        rd_beat = 1'b0;
  logic [1:0]  rd_be = 2'b00;
  logic        wr_beat = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] dq_in;
  logic        dq_oe, dqm_lo, dqm_hi, rd_valid;
  logic [15:0] dq_out, rd_data;
  logic [1:0]  rd_byte_valid;

  int checks = 0;
  int failures = 0;
  int e = 0;
  bit done = 0;

  bit         s_v [64];
  logic [1:0] s_be[64];
  logic [15:0] s_d[64];

  always #2.5 clk = ~clk;
  always @(posedge clk) e <= e + 1;

  function automatic logic [15:0] bus_pat(input int x);
    logic [7:0] l;
    l = x[7:0];
    return {l ^ 8'hA5, l + 8'h3C};
  endfunction

  assign dq_in = bus_pat(e);

  sdram_dqpath i_sdram_dqpath (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_beat(rd_beat), .rd_be(rd_be),
    .wr_beat(wr_beat), .wr_data(wr_data), .wr_be(wr_be), .dq_in(dq_in),
    .dq_oe(dq_oe), .dq_out(dq_out), .dqm_lo(dqm_lo), .dqm_hi(dqm_hi),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_byte_valid(rd_byte_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, expv, e);
    end
  endtask

  function automatic logic [15:0] masked(input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
  endfunction

  // called just after a falling edge; drives one clock of stimulus
  task automatic step(input bit rd, input logic [1:0] rbe, input bit wr,
                      input logic [1:0] wbe, input logic [15:0] wd);
    int c, lat;
    bit guard, ok, mact;
    logic [1:0] mexp;
    rd_beat = rd; rd_be = rbe; wr_beat = wr; wr_be = wbe; wr_data = wd;
    lat = cas_lat ? 3 : 2;
    if (rd) begin
      c = e + 1 + lat;
      s_v[c % 64] = 1'b1;
      s_be[c % 64] = rbe;
      s_d[c % 64] = masked(bus_pat(c - 1), rbe);
    end
    #1;
    guard = s_v[(e + 1) % 64] | s_v[(e + 2) % 64];
    ok = wr && !rd && !guard;
    mact = s_v[(e + 3) % 64];
    if (ok)        mexp = ~wbe;
    else if (mact) mexp = ~s_be[(e + 3) % 64];
    else           mexp = 2'b11;
    if (ok) begin
      check(dq_oe == 1'b1 && dq_out == wd, "R1 write drive", {15'd0, dq_oe, dq_out},
            {16'd1, wd});
      check({dqm_hi, dqm_lo} == mexp, "R2 write mask", {30'd0, dqm_hi, dqm_lo}, {30'd0, mexp});
    end else if (wr) begin
      check(dq_oe == 1'b0 && dq_out == 16'h0, "R7 write dropped", {15'd0, dq_oe, dq_out}, 0);
      check({dqm_hi, dqm_lo} == mexp, "R7 mask on dropped write", {30'd0, dqm_hi, dqm_lo},
            {30'd0, mexp});
    end else if (mact) begin
      check({dqm_hi, dqm_lo} == mexp && !dq_oe, "R5 read mask lead", {29'd0, dq_oe, dqm_hi, dqm_lo},
            {30'd0, mexp});
    end else begin
      check(!dq_oe && dq_out == 16'h0 && {dqm_hi, dqm_lo} == 2'b11, "R8 idle pins",
            {13'd0, dq_oe, dqm_hi, dqm_lo, dq_out}, {16'd3, 16'd0});
    end
    @(posedge clk);
    @(negedge clk);
    if (s_v[e % 64]) begin
      check(rd_valid == 1'b1, cas_lat ? "R4 latency 3 return" : "R3 latency 2 return",
            {31'd0, rd_valid}, 1);
      check(rd_byte_valid == s_be[e % 64] && rd_data == s_d[e % 64], "R6 byte valid and data",
            {14'd0, rd_byte_valid, rd_data}, {14'd0, s_be[e % 64], s_d[e % 64]});
    end else begin
      check(rd_valid == 1'b0 && rd_byte_valid == 2'b00, "R3 R4 no stray read word",
            {29'd0, rd_valid, rd_byte_valid}, 0);
    end
    s_v[e % 64] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b0, 2'b00, 16'h0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5D0A11;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) s_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(rd_valid == 1'b0 && rd_byte_valid == 2'b00, "R9 reset outputs",
          {29'd0, rd_valid, rd_byte_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0 && rd_byte_valid == 2'b00, "R9 after reset",
          {29'd0, rd_valid, rd_byte_valid}, 0);
    idle(2);
    // directed: latency 2 single reads, each byte alone
    cas_lat = 1'b0;
    step(1'b1, 2'b11, 1'b0, 2'b00, 0); idle(5);
    step(1'b1, 2'b01, 1'b0, 2'b00, 0); idle(5);
    // write into the turnaround window of a latency 2 read (R7)
    step(1'b1, 2'b10, 1'b0, 2'b00, 0);
    step(1'b0, 2'b00, 1'b1, 2'b11, 16'hBEEF);
    step(1'b0, 2'b00, 1'b1, 2'b01, 16'h1234);
    step(1'b0, 2'b00, 1'b1, 2'b10, 16'h5678);
    idle(5);
    // write on the read command clock (R7)
    step(1'b1, 2'b11, 1'b1, 2'b11, 16'hCAFE); idle(5);
    // latency 3, back-to-back reads with differing enables (R4, R5, R6)
    cas_lat = 1'b1;
    step(1'b1, 2'b10, 1'b0, 2'b00, 0);
    step(1'b1, 2'b01, 1'b0, 2'b00, 0);
    step(1'b1, 2'b00, 1'b0, 2'b00, 0);
    step(1'b0, 2'b00, 1'b1, 2'b11, 16'hA55A);
    idle(6);
    // standalone writes, single byte (R1, R2)
    step(1'b0, 2'b00, 1'b1, 2'b01, 16'h00FF);
    step(1'b0, 2'b00, 1'b1, 2'b10, 16'hFF00);
    idle(2);
    // constrained random phases at both latencies
    for (int ph = 0; ph < 8; ph++) begin
      cas_lat = ph[0];
      for (int i = 0; i < 250; i++) begin
        bit r, w;
        r = ($urandom % 4) == 0;
        w = ($urandom % 5) < 2;
        step(r, 2'($urandom), w, 2'($urandom), 16'($urandom));
      end
      idle(6);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule